// File: doc/BRIEF.md
# Receive FIFO Pause Flow Controller

This block sits beside a receive packet FIFO and decides when the link partner should be told to stop sending and when it may start again. It compares the FIFO's byte fill level against two watermarks. The first is an activation point, at which a pause request is raised. The second is a deactivation point, at which a zero-time pause request is raised so the partner resumes. Each watermark is given as a 6-bit code that counts half-kilobyte steps below full, with a fixed bias of two steps. Requests go to a transmit framer over a valid/acknowledge handshake and carry the pause quanta value.

The same block also obeys pause frames from the partner. A received pause value loads a down-counter. The counter steps once per quanta tick, where one tick stands for 512 bit times. While the counter is non-zero, the transmit-allowed flag stays low. Issuing requests and obeying received pauses have separate enables. Request generation also needs the FIFO to be at least 4 KB: size code 15 or more, where the code is bytes/256 − 1.

Top module: `rx_pause_ctrl`

## Requirements
- R1: During and right after reset, pause_req_o is 0, paused_o is 0, pause_time_o is 0 and tx_allowed_o is 1.
- R2: In the not-paused state, with all generation enables set and the size code at least 15, a fill level at or above full − (act_code + 2) × 512 bytes raises pause_req_o in the next cycle. The request carries the pause_time_i value that was sampled at that edge. Here full = (size_code + 1) × 256.
- R3: pause_req_o stays high with pause_time_o unchanged until pause_ack_i is seen at a clock edge. After an acknowledged pause, no further request is made while the fill stays high. paused_o is 1 after the acknowledge.
- R4: While paused, a fill level at or below full − (deact_code + 2) × 512 bytes raises one request with pause time 0. After it is acknowledged, paused_o returns to 0. A fill level one byte above that point raises nothing.
- R5: With a size code below 15, the generation enable has no effect and no request is made at any fill level. Size code 15 is accepted.
- R6: When hw_fc_en_i or tx_fc_en_i is 0, no request starts. If either is cleared while paused and no request is pending, paused_o drops to 0 without a request.
- R7: A watermark whose offset reaches or exceeds the FIFO size is taken as fill level 0.
- R8: With equal or reversed watermarks, the paused state ends only through an acknowledged zero-time request. paused_o stays 1 for as long as that request is pending.
- R9: With rx_fc_en_i set, rx_pause_valid_i loads rx_pause_time_i into the counter. tx_allowed_o is 0 from the next cycle until exactly that many quanta ticks have occurred.
- R10: With rx_fc_en_i clear, a received pause has no effect and tx_allowed_o stays 1.
- R11: A new received pause value replaces the running count. A value of 0 makes tx_allowed_o 1 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fill_bytes_i | input | FILL_W | Receive FIFO fill level in bytes |
| size_code_i | input | SIZE_W | FIFO size code, bytes/256 − 1 |
| hw_fc_en_i | input | 1 | Hardware flow control enable |
| tx_fc_en_i | input | 1 | Allow pause frames to be sent |
| act_code_i | input | THR_W | Activation watermark code |
| deact_code_i | input | THR_W | Deactivation watermark code |
| pause_time_i | input | PT_W | Pause quanta used for a stop request |
| pause_req_o | output | 1 | Pause request valid to the framer |
| pause_ack_i | input | 1 | Framer accepts the request |
| pause_time_o | output | PT_W | Quanta carried by the request |
| paused_o | output | 1 | Partner has been asked to stop |
| rx_fc_en_i | input | 1 | Obey received pause frames |
| rx_pause_valid_i | input | 1 | A pause frame was received |
| rx_pause_time_i | input | PT_W | Quanta of the received pause |
| quanta_tick_i | input | 1 | One pulse per 512 bit times |
| tx_allowed_o | output | 1 | Transmission currently allowed |

## Verification
The bench targets each watermark at its exact byte and one byte short of it. An off-by-one in the bias or step would miss one of these. It also drives size codes 14 and 15: a wrong size gate would pause on a small FIFO or refuse a 4 KB one. Offsets equal to the FIFO size catch a watermark that wraps to a large value instead of clamping at 0. Equal and reversed watermarks are tested to show the paused state clears only through the acknowledged zero-time request, and the pause time is changed while a request is pending to catch a time that does not stay stable. The receive counter is checked one tick before and at its release, and again when a new value overrides it.

// File: rtl/rxfc_pkg.sv
package rxfc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_REQ_ON,
    ST_PAUSED,
    ST_REQ_OFF
  } fc_state_e;

  localparam int unsigned MIN_SIZE_CODE = 15;  // 4 KB
  localparam int unsigned THR_BIAS      = 2;
  localparam int unsigned THR_STEP_LG   = 9;   // 512 B steps
  localparam int unsigned SIZE_UNIT_LG  = 8;   // 256 B units
endpackage

// File: rtl/rxfc_thresh.sv
module rxfc_thresh
  import rxfc_pkg::*;
#(
  parameter int unsigned SIZE_W = 10,
  parameter int unsigned THR_W  = 6,
  parameter int unsigned FILL_W = SIZE_W + 9
) (
  input  logic [SIZE_W-1:0] size_code_i,
  input  logic [THR_W-1:0]  thr_code_i,
  output logic [FILL_W-1:0] point_o
);
  localparam int unsigned CALC_W = FILL_W + THR_W + THR_STEP_LG;

  logic [CALC_W-1:0] full_b, off_b;

  always_comb begin
    full_b  = (CALC_W'(size_code_i) + CALC_W'(1)) << SIZE_UNIT_LG;
    off_b   = (CALC_W'(thr_code_i) + CALC_W'(THR_BIAS)) << THR_STEP_LG;
    point_o = (off_b >= full_b) ? '0 : FILL_W'(full_b - off_b);
  end
endmodule

// File: rtl/rxfc_req_fsm.sv
module rxfc_req_fsm
  import rxfc_pkg::*;
#(
  parameter int unsigned FILL_W = 19,
  parameter int unsigned PT_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILL_W-1:0] fill_i,
  input  logic [FILL_W-1:0] act_pt_i,
  input  logic [FILL_W-1:0] deact_pt_i,
  input  logic              gen_en_i,
  input  logic [PT_W-1:0]   pause_time_i,
  input  logic              ack_i,
  output logic              req_o,
  output logic [PT_W-1:0]   time_o,
  output logic              paused_o
);
  fc_state_e state_q, state_d;
  logic [PT_W-1:0] time_q, time_d;

  always_comb begin
    state_d = state_q;
    time_d  = time_q;
    unique case (state_q)
      ST_IDLE: if (gen_en_i && fill_i >= act_pt_i) begin
        state_d = ST_REQ_ON;
        time_d  = pause_time_i;
      end
      ST_REQ_ON:  if (ack_i) state_d = ST_PAUSED;
      ST_PAUSED: begin
        if (!gen_en_i) state_d = ST_IDLE;
        else if (fill_i <= deact_pt_i) begin
          state_d = ST_REQ_OFF;
          time_d  = '0;
        end
      end
      ST_REQ_OFF: if (ack_i) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      time_q  <= '0;
    end else begin
      state_q <= state_d;
      time_q  <= time_d;
    end
  end

  assign req_o    = (state_q == ST_REQ_ON) || (state_q == ST_REQ_OFF);
  assign paused_o = (state_q == ST_PAUSED) || (state_q == ST_REQ_OFF);
  assign time_o   = time_q;
endmodule

// File: rtl/rxfc_quanta_timer.sv
module rxfc_quanta_timer #(
  parameter int unsigned PT_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [PT_W-1:0] load_val_i,
  input  logic            tick_i,
  output logic            idle_o
);
  logic [PT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (tick_i && cnt_q != '0) cnt_q <= cnt_q - PT_W'(1);
  end

  assign idle_o = (cnt_q == '0);
endmodule

// File: rtl/rx_pause_ctrl.sv
module rx_pause_ctrl
  import rxfc_pkg::*;
#(
  parameter int unsigned SIZE_W = 10,
  parameter int unsigned THR_W  = 6,
  parameter int unsigned PT_W   = 16,
  parameter int unsigned FILL_W = SIZE_W + 9
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [FILL_W-1:0] fill_bytes_i,
  input  logic [SIZE_W-1:0] size_code_i,
  input  logic              hw_fc_en_i,
  input  logic              tx_fc_en_i,
  input  logic [THR_W-1:0]  act_code_i,
  input  logic [THR_W-1:0]  deact_code_i,
  input  logic [PT_W-1:0]   pause_time_i,
  output logic              pause_req_o,
  input  logic              pause_ack_i,
  output logic [PT_W-1:0]   pause_time_o,
  output logic              paused_o,
  input  logic              rx_fc_en_i,
  input  logic              rx_pause_valid_i,
  input  logic [PT_W-1:0]   rx_pause_time_i,
  input  logic              quanta_tick_i,
  output logic              tx_allowed_o
);
  localparam int unsigned N_THR = 2;

  logic [THR_W-1:0]  thr_code [N_THR];
  logic [FILL_W-1:0] thr_pt   [N_THR];
  logic              size_ok, gen_en;

  assign thr_code[0] = act_code_i;
  assign thr_code[1] = deact_code_i;

  for (genvar g = 0; g < N_THR; g++) begin : g_thr
    rxfc_thresh #(
      .SIZE_W(SIZE_W), .THR_W(THR_W), .FILL_W(FILL_W)
    ) i_thresh (
      .size_code_i(size_code_i),
      .thr_code_i (thr_code[g]),
      .point_o    (thr_pt[g])
    );
  end

  // Enable ignored below the minimum FIFO size
  assign size_ok = (size_code_i >= SIZE_W'(MIN_SIZE_CODE));
  assign gen_en  = hw_fc_en_i && tx_fc_en_i && size_ok;

  rxfc_req_fsm #(.FILL_W(FILL_W), .PT_W(PT_W)) i_req_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_i      (fill_bytes_i),
    .act_pt_i    (thr_pt[0]),
    .deact_pt_i  (thr_pt[1]),
    .gen_en_i    (gen_en),
    .pause_time_i(pause_time_i),
    .ack_i       (pause_ack_i),
    .req_o       (pause_req_o),
    .time_o      (pause_time_o),
    .paused_o    (paused_o)
  );

  rxfc_quanta_timer #(.PT_W(PT_W)) i_timer (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (rx_pause_valid_i && rx_fc_en_i),
    .load_val_i(rx_pause_time_i),
    .tick_i    (quanta_tick_i),
    .idle_o    (tx_allowed_o)
  );
endmodule

// File: rtl/rx_pause_ctrl_chk.sv
module rx_pause_ctrl_chk #(
  parameter int unsigned SIZE_W = 10,
  parameter int unsigned PT_W   = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [SIZE_W-1:0] size_code_i,
  input logic [PT_W-1:0]   pause_time_i,
  input logic              pause_req_o,
  input logic              pause_ack_i,
  input logic [PT_W-1:0]   pause_time_o,
  input logic              paused_o,
  input logic              rx_fc_en_i,
  input logic              rx_pause_valid_i,
  input logic              quanta_tick_i,
  input logic              tx_allowed_o
);
  // R1
  always_comb if (!rst_ni) reset_state_chk: assert (!pause_req_o && !paused_o && tx_allowed_o);

  // R2
  on_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_req_o) && !paused_o |-> pause_time_o == $past(pause_time_i));

  // R3
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pause_req_o && !pause_ack_i |=> pause_req_o && $stable(pause_time_o));

  // R4
  off_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pause_req_o) && paused_o |-> pause_time_o == '0);

  // R5
  small_fifo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pause_req_o && !paused_o && size_code_i < SIZE_W'(15) |=> !pause_req_o);

  // R8
  paused_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    paused_o && pause_req_o && !pause_ack_i |=> paused_o);

  // R9
  count_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_allowed_o && !quanta_tick_i && !(rx_pause_valid_i && rx_fc_en_i) |=> !tx_allowed_o);

  // R10
  ignore_rx_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_allowed_o && !rx_fc_en_i |=> tx_allowed_o);
endmodule

bind rx_pause_ctrl rx_pause_ctrl_chk #(.SIZE_W(SIZE_W), .PT_W(PT_W)) i_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .size_code_i     (size_code_i),
  .pause_time_i    (pause_time_i),
  .pause_req_o     (pause_req_o),
  .pause_ack_i     (pause_ack_i),
  .pause_time_o    (pause_time_o),
  .paused_o        (paused_o),
  .rx_fc_en_i      (rx_fc_en_i),
  .rx_pause_valid_i(rx_pause_valid_i),
  .quanta_tick_i   (quanta_tick_i),
  .tx_allowed_o    (tx_allowed_o)
);

// File: tb/test_rx_pause_ctrl.sv
module test_rx_pause_ctrl;
  localparam int unsigned SIZE_W = 10;
  localparam int unsigned THR_W  = 6;
  localparam int unsigned PT_W   = 16;
  localparam int unsigned FILL_W = 19;

  logic clk = 0, rst_ni = 0;
  logic [FILL_W-1:0] fill = '0;
  logic [SIZE_W-1:0] size_code = '0;
  logic hw_en = 0, tx_en = 1, ack = 0;
  logic [THR_W-1:0] act_code = '0, deact_code = '0;
  logic [PT_W-1:0] ptime = 16'hFFFF, ptime_o, rx_time = '0;
  logic req, paused, rx_en = 0, rx_valid = 0, qtick = 0, allowed;

  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  rx_pause_ctrl #(.SIZE_W(SIZE_W), .THR_W(THR_W), .PT_W(PT_W), .FILL_W(FILL_W)) i_rx_pause_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .fill_bytes_i(fill), .size_code_i(size_code),
    .hw_fc_en_i(hw_en), .tx_fc_en_i(tx_en), .act_code_i(act_code),
    .deact_code_i(deact_code), .pause_time_i(ptime), .pause_req_o(req),
    .pause_ack_i(ack), .pause_time_o(ptime_o), .paused_o(paused),
    .rx_fc_en_i(rx_en), .rx_pause_valid_i(rx_valid), .rx_pause_time_i(rx_time),
    .quanta_tick_i(qtick), .tx_allowed_o(allowed)
  );

  typedef struct packed {
    logic [SIZE_W-1:0] size;
    logic [THR_W-1:0]  act;
    logic [FILL_W-1:0] fill;
    logic              exp;
  } vec_t;

  // R2 edges, R5 size gate, R7 clamp
  localparam vec_t VECS [8] = '{
    '{10'd15, 6'd1,  19'd2560, 1'b1},
    '{10'd15, 6'd1,  19'd2559, 1'b0},
    '{10'd31, 6'd10, 19'd2048, 1'b1},
    '{10'd31, 6'd10, 19'd2047, 1'b0},
    '{10'd14, 6'd1,  19'd3840, 1'b0},
    '{10'd63, 6'd18, 19'd6144, 1'b1},
    '{10'd15, 6'd10, 19'd0,    1'b1},
    '{10'd15, 6'd6,  19'd0,    1'b1}
  };

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all requirements actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    cyc(2);
    chk("R1 req in reset", req, 0);
    chk("R1 allowed in reset", allowed, 1);
    rst_ni = 1; cyc();
    chk("R1 req", req, 0);
    chk("R1 paused", paused, 0);
    chk("R1 time", ptime_o, 0);
    chk("R1 allowed", allowed, 1);

    foreach (VECS[i]) begin
      hw_en = 0; size_code = VECS[i].size; act_code = VECS[i].act;
      deact_code = 0; fill = VECS[i].fill; cyc();
      hw_en = 1; cyc();
      chk($sformatf("R2 R5 R7 vec %0d req", i), req, VECS[i].exp);
      if (VECS[i].exp) begin
        chk($sformatf("R2 vec %0d time", i), ptime_o, 16'hFFFF);
        do_ack();
        chk($sformatf("R3 vec %0d paused", i), paused, 1);
        fill = 0; cyc();
        chk($sformatf("R4 vec %0d off req", i), req, 1);
        chk($sformatf("R4 vec %0d off time", i), ptime_o, 0);
        ack = 1; hw_en = 0; cyc(); ack = 0;
        chk($sformatf("R4 vec %0d cleared", i), paused, 0);
      end else begin
        hw_en = 0; cyc();
      end
    end

    // R3 hold, single request; R4 exact deact point; R8 pending off
    size_code = 31; act_code = 2; deact_code = 6; ptime = 16'h1234;
    fill = 7000; hw_en = 1; cyc();
    chk("R2 req", req, 1);
    chk("R2 time", ptime_o, 16'h1234);
    ptime = 16'hAAAA; cyc(3);
    chk("R3 held", req, 1);
    chk("R3 time stable", ptime_o, 16'h1234);
    do_ack();
    chk("R3 dropped", req, 0);
    chk("R3 paused", paused, 1);
    cyc(3);
    chk("R3 no repeat", req, 0);
    fill = 4097; cyc(2);
    chk("R4 above point", req, 0);
    fill = 4096; cyc();
    chk("R4 off req", req, 1);
    chk("R4 off time", ptime_o, 0);
    cyc();
    chk("R8 paused while pending", paused, 1);
    ack = 1; hw_en = 0; cyc(); ack = 0;
    chk("R4 cleared", paused, 0);

    // R6 enables
    tx_en = 0; hw_en = 1; fill = 7000; cyc(2);
    chk("R6 tx disabled", req, 0);
    tx_en = 1; cyc();
    chk("R6 tx enabled", req, 1);
    do_ack();
    chk("R6 paused", paused, 1);
    hw_en = 0; cyc();
    chk("R6 silent clear", paused, 0);
    chk("R6 no req", req, 0);

    // R8 reversed watermarks
    act_code = 6; deact_code = 2; fill = 5000; hw_en = 1; cyc();
    chk("R8 on req", req, 1);
    do_ack();
    chk("R8 paused", paused, 1);
    chk("R8 req idle", req, 0);
    cyc();
    chk("R8 off req", req, 1);
    chk("R8 off time", ptime_o, 0);
    chk("R8 still paused", paused, 1);
    ack = 1; hw_en = 0; cyc(); ack = 0;
    chk("R8 cleared", paused, 0);

    // R10 ignore
    rx_en = 0; rx_valid = 1; rx_time = 50; cyc(); rx_valid = 0; cyc();
    chk("R10 ignored", allowed, 1);

    // R9 count
    rx_en = 1; rx_valid = 1; rx_time = 3; cyc(); rx_valid = 0;
    chk("R9 blocked", allowed, 0);
    for (int k = 0; k < 3; k++) begin
      qtick = 1; cyc(); qtick = 0; cyc();
      chk($sformatf("R9 tick %0d", k + 1), allowed, (k == 2));
    end

    // R11 override
    rx_valid = 1; rx_time = 100; cyc();
    chk("R11 loaded", allowed, 0);
    rx_time = 0; cyc();
    chk("R11 zero release", allowed, 1);
    rx_time = 100; cyc();
    rx_time = 2; cyc(); rx_valid = 0;
    qtick = 1; cyc();
    chk("R11 one left", allowed, 0);
    cyc(); qtick = 0;
    chk("R11 new count done", allowed, 1);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule